// File: doc/BRIEF.md
# Peripheral clock-enable and reset sequencer

This block brings a single peripheral up safely when software asks for its clock, and takes it down again on request. It does not own the control bank. It reads back the peripheral's clock bit and reset bit from that bank. It changes those bits only through one-cycle write strobes: set-clock, clear-clock, set-reset and clear-reset.

An enable request on a peripheral that has a reset line starts a timed sequence:

1. Put the peripheral into reset.
2. Hold it there for a short wait.
3. Ungate its clock, using the polarity that this peripheral's clock bit needs.
4. Wait a longer settle time.
5. Release reset.

A peripheral without a reset line only has its clock ungated. A disable request only gates the clock. The status output reports the peripheral as enabled only when it is out of reset and its clock bit holds the enabling value.

Both waits are given in microseconds and turned into cycle counts from a clock-frequency parameter. A testbench can therefore shorten them by lowering that frequency.

Top module: `pclk_seq`

## Requirements
- R1: After reset, `busy_o` is low and none of the four write strobes (`clk_set_o`, `clk_clr_o`, `rst_set_o`, `rst_clr_o`) is high until a request arrives.
- R2: An enable request while `enabled_o` is high causes no write strobe at all, and `busy_o` stays low.
- R3: With a reset line present (HAS_RESET=1), an enable request on a disabled peripheral pulses `rst_set_o` in the cycle after the request is sampled, and `busy_o` is high from that cycle on.
- R4: The clock is ungated exactly WAIT_RST cycles after the `rst_set_o` pulse. With CLK_EN_HIGH=1 this is a `clk_set_o` pulse, and with CLK_EN_HIGH=0 it is a `clk_clr_o` pulse.
- R5: `rst_clr_o` pulses exactly WAIT_SETTLE cycles after the ungating pulse. `busy_o` is low in that same cycle and stays low afterwards.
- R6: With no reset line (HAS_RESET=0), an enable request on a disabled peripheral gives only the ungating pulse, in the cycle after the request. There is no reset strobe, and `busy_o` stays low.
- R7: `enabled_o` is 0 whenever HAS_RESET=1 and `rst_bit_i`=1, even if the clock runs. In every other case `enabled_o` = (`clk_bit_i` == CLK_EN_HIGH).
- R8: A disable request gives a single gating pulse in the cycle after it is sampled: `clk_clr_o` when CLK_EN_HIGH=1, `clk_set_o` when CLK_EN_HIGH=0. It never pulses either reset strobe.
- R9: Enable and disable requests that arrive while `busy_o` is high are ignored. During a sequence no gating pulse is issued, and the ungating and reset-release pulses each appear exactly once.
- R10: When enable and disable are requested in the same idle cycle, the enable request is served and the disable request is dropped.
- R11: WAIT_RST = max(1, CLK_HZ*RST_US/1000000) cycles and WAIT_SETTLE = max(1, CLK_HZ*SETTLE_US/1000000) cycles. By default RST_US is 100 and SETTLE_US is 10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, whose rate is CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req_i | input | 1 | Request to enable the peripheral's clock |
| dis_req_i | input | 1 | Request to stop the peripheral's clock |
| clk_bit_i | input | 1 | Current value of the peripheral's clock bit in the bank |
| rst_bit_i | input | 1 | Current value of the peripheral's reset bit in the bank (1 = held in reset) |
| clk_set_o | output | 1 | One-cycle strobe that sets the clock bit |
| clk_clr_o | output | 1 | One-cycle strobe that clears the clock bit |
| rst_set_o | output | 1 | One-cycle strobe that puts the peripheral into reset |
| rst_clr_o | output | 1 | One-cycle strobe that releases the peripheral from reset |
| busy_o | output | 1 | High while a reset-wrapped enable sequence is running |
| enabled_o | output | 1 | Peripheral reported as enabled |

## Verification
The bench builds two instances.

The first has a reset line and an active-low clock bit, with CLK_HZ=100000. That turns the 100 µs and 10 ms waits into 10 and 1000 cycles, so the whole three-step sequence fits in a short run. Every cycle of it can be watched for stray pulses, and requests can be injected in the middle of it.

The second has no reset line and an active-high clock bit, with CLK_HZ=200000. Together the two instances cover both clock polarities and both sequence variants.

The status decode is swept over all four clock-bit and reset-bit combinations on both instances.

// File: rtl/pclk_seq_pkg.sv
package pclk_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  // Cycle count for a wait of 'us' microseconds at 'hz', never below one.
  function automatic int unsigned wait_cycles(input longint unsigned hz,
                                              input longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1000000;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // Reported status: reset dominates, otherwise compare with enabling value.
  function automatic logic status_of(input logic has_rst, input logic en_val,
                                     input logic clk_bit, input logic rst_bit);
    if (has_rst && rst_bit) return 1'b0;
    return (clk_bit == en_val);
  endfunction

endpackage

// File: rtl/pclk_seq_timer.sv
module pclk_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pclk_seq_status.sv
module pclk_seq_status #(
  parameter bit HAS_RESET   = 1'b1,
  parameter bit CLK_EN_HIGH = 1'b0
) (
  input  logic clk_bit,
  input  logic rst_bit,
  output logic enabled
);
  assign enabled = pclk_seq_pkg::status_of(HAS_RESET, CLK_EN_HIGH, clk_bit, rst_bit);
endmodule

// File: rtl/pclk_seq_fsm.sv
module pclk_seq_fsm #(
  parameter bit HAS_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  input  logic enabled,
  input  logic tmr_zero,
  output logic start_seq,
  output logic hold_done,
  output logic busy,
  output logic clk_on,
  output logic clk_off,
  output logic rst_on,
  output logic rst_off
);
  import pclk_seq_pkg::*;

  seq_state_e st_q;
  logic       en_take;
  logic       dis_take;
  logic       settle_done;

  // Enable has priority over disable when both arrive in an idle cycle.
  assign en_take     = (st_q == ST_IDLE) && en_req && !enabled;
  assign dis_take    = (st_q == ST_IDLE) && !en_req && dis_req;
  assign start_seq   = en_take && HAS_RESET;
  assign hold_done   = (st_q == ST_HOLD) && tmr_zero;
  assign settle_done = (st_q == ST_SETTLE) && tmr_zero;
  assign busy        = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      clk_on  <= 1'b0;
      clk_off <= 1'b0;
      rst_on  <= 1'b0;
      rst_off <= 1'b0;
    end else begin
      clk_on  <= (en_take && !HAS_RESET) || hold_done;
      clk_off <= dis_take;
      rst_on  <= start_seq;
      rst_off <= settle_done;
      case (st_q)
        ST_IDLE:   if (start_seq) st_q <= ST_HOLD;
        ST_HOLD:   if (hold_done) st_q <= ST_SETTLE;
        ST_SETTLE: if (settle_done) st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pclk_seq.sv
module pclk_seq #(
  parameter int unsigned CLK_HZ      = 100000000,
  parameter int unsigned RST_US      = 100,
  parameter int unsigned SETTLE_US   = 10000,
  parameter bit          HAS_RESET   = 1'b1,
  parameter bit          CLK_EN_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req_i,
  input  logic dis_req_i,
  input  logic clk_bit_i,
  input  logic rst_bit_i,
  output logic clk_set_o,
  output logic clk_clr_o,
  output logic rst_set_o,
  output logic rst_clr_o,
  output logic busy_o,
  output logic enabled_o
);
  localparam int unsigned WAIT_RST    = pclk_seq_pkg::wait_cycles(CLK_HZ, RST_US);
  localparam int unsigned WAIT_SETTLE = pclk_seq_pkg::wait_cycles(CLK_HZ, SETTLE_US);
  localparam int unsigned WAIT_MAX    = (WAIT_RST > WAIT_SETTLE) ? WAIT_RST : WAIT_SETTLE;
  localparam int          CW          = $clog2(WAIT_MAX + 1);

  // Named internal events, visible to the bound checker.
  logic enabled;
  logic tmr_zero;
  logic start_seq;
  logic hold_done;
  logic clk_on;
  logic clk_off;
  logic busy;

  pclk_seq_status #(.HAS_RESET(HAS_RESET), .CLK_EN_HIGH(CLK_EN_HIGH)) u_status (
    .clk_bit (clk_bit_i),
    .rst_bit (rst_bit_i),
    .enabled (enabled)
  );

  pclk_seq_fsm #(.HAS_RESET(HAS_RESET)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req_i),
    .dis_req   (dis_req_i),
    .enabled   (enabled),
    .tmr_zero  (tmr_zero),
    .start_seq (start_seq),
    .hold_done (hold_done),
    .busy      (busy),
    .clk_on    (clk_on),
    .clk_off   (clk_off),
    .rst_on    (rst_set_o),
    .rst_off   (rst_clr_o)
  );

  generate
    if (HAS_RESET) begin : g_timer
      logic          tmr_load;
      logic [CW-1:0] tmr_val;
      assign tmr_load = start_seq || hold_done;
      assign tmr_val  = start_seq ? CW'(WAIT_RST - 1) : CW'(WAIT_SETTLE - 1);
      pclk_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
      );
    end else begin : g_no_timer
      assign tmr_zero = 1'b1;
    end

    if (CLK_EN_HIGH) begin : g_en_high
      assign clk_set_o = clk_on;
      assign clk_clr_o = clk_off;
    end else begin : g_en_low
      assign clk_set_o = clk_off;
      assign clk_clr_o = clk_on;
    end
  endgenerate

  assign busy_o    = busy;
  assign enabled_o = enabled;
endmodule

// File: rtl/pclk_seq_chk.sv
module pclk_seq_chk #(
  parameter bit          HAS_RESET   = 1'b1,
  parameter int unsigned WAIT_RST    = 1,
  parameter int unsigned WAIT_SETTLE = 1
) (
  input logic clk,
  input logic rst_n,
  input logic en_req,
  input logic dis_req,
  input logic enabled,
  input logic busy,
  input logic clk_on,
  input logic clk_off,
  input logic rst_set,
  input logic rst_clr
);
  logic [31:0] since_rst_q;
  logic [31:0] since_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst_q <= '0;
      since_on_q  <= '0;
    end else begin
      since_rst_q <= rst_set ? 32'd1 : ((since_rst_q == '1) ? since_rst_q : since_rst_q + 32'd1);
      since_on_q  <= clk_on  ? 32'd1 : ((since_on_q  == '1) ? since_on_q  : since_on_q  + 32'd1);
    end
  end

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_on, clk_off, rst_set, rst_clr}));

  a_r2_enabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !busy && enabled) |=> !(clk_on || clk_off || rst_set || rst_clr));

  a_r3_busy_opens_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rst_set);

  a_r4_ungate_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_RESET && clk_on) |-> (since_rst_q == WAIT_RST));

  a_r5_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rst_clr |-> (since_on_q == WAIT_SETTLE && !busy));

  a_r6_plain_ungate: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_RESET && en_req && !enabled) |=> (clk_on && !busy && !rst_set));

  a_r8_disable_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && !en_req && !busy) |=> (clk_off && !rst_set && !rst_clr));

  a_r9_no_gate_in_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !clk_off);
endmodule

bind pclk_seq pclk_seq_chk #(
  .HAS_RESET   (HAS_RESET),
  .WAIT_RST    (WAIT_RST),
  .WAIT_SETTLE (WAIT_SETTLE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_req  (en_req_i),
  .dis_req (dis_req_i),
  .enabled (enabled),
  .busy    (busy),
  .clk_on  (clk_on),
  .clk_off (clk_off),
  .rst_set (rst_set_o),
  .rst_clr (rst_clr_o)
);

// File: tb/pclk_seq_tb.sv
`timescale 1ns/1ps
module pclk_seq_tb;
  // R11: cycle counts restated from microseconds at the bench clock rates.
  localparam int A_HZ = 100000;
  localparam int B_HZ = 200000;
  localparam int A_R  = A_HZ / 10000;        // 100 us
  localparam int A_S  = A_HZ / 100;          // 10 ms

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  // Instance A: reset line present, clock bit enables at 0.
  logic a_en = 0, a_dis = 0, a_cb, a_rb, a_ld = 0;
  logic [1:0] a_ldv = '0;
  logic a_cs, a_cc, a_rs, a_rc, a_busy, a_enab;
  // Instance B: no reset line, clock bit enables at 1.
  logic b_en = 0, b_dis = 0, b_cb, b_rb, b_ld = 0;
  logic [1:0] b_ldv = '0;
  logic b_cs, b_cc, b_rs, b_rc, b_busy, b_enab;

  pclk_seq #(.CLK_HZ(A_HZ), .HAS_RESET(1'b1), .CLK_EN_HIGH(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_req_i(a_en), .dis_req_i(a_dis),
    .clk_bit_i(a_cb), .rst_bit_i(a_rb), .clk_set_o(a_cs), .clk_clr_o(a_cc),
    .rst_set_o(a_rs), .rst_clr_o(a_rc), .busy_o(a_busy), .enabled_o(a_enab));

  pclk_seq #(.CLK_HZ(B_HZ), .HAS_RESET(1'b0), .CLK_EN_HIGH(1'b1)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .en_req_i(b_en), .dis_req_i(b_dis),
    .clk_bit_i(b_cb), .rst_bit_i(b_rb), .clk_set_o(b_cs), .clk_clr_o(b_cc),
    .rst_set_o(b_rs), .rst_clr_o(b_rc), .busy_o(b_busy), .enabled_o(b_enab));

  // Bank models: strobes land one edge later; bench can load a value.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_cb <= 1'b1; a_rb <= 1'b1;
    end else if (a_ld) begin
      {a_cb, a_rb} <= a_ldv;
    end else begin
      if (a_cs) a_cb <= 1'b1;
      if (a_cc) a_cb <= 1'b0;
      if (a_rs) a_rb <= 1'b1;
      if (a_rc) a_rb <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      b_cb <= 1'b0; b_rb <= 1'b0;
    end else if (b_ld) begin
      {b_cb, b_rb} <= b_ldv;
    end else begin
      if (b_cs) b_cb <= 1'b1;
      if (b_cc) b_cb <= 1'b0;
      if (b_rs) b_rb <= 1'b1;
      if (b_rc) b_rb <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_a(input logic cb, input logic rb);
    a_ldv = {cb, rb}; a_ld = 1'b1;
    @(negedge clk); a_ld = 1'b0;
  endtask

  task automatic load_b(input logic cb, input logic rb);
    b_ldv = {cb, rb}; b_ld = 1'b1;
    @(negedge clk); b_ld = 1'b0;
  endtask

  // Full sequence on A; optional mid-sequence injection of both requests.
  task automatic run_a_enable(input bit with_dis, input bit inject);
    int k_rs = -1, k_cc = -1, k_rc = -1;
    int n_rs = 0, n_cc = 0, n_rc = 0, n_cs = 0, n_busy = 0;
    int held_enab = -1;
    a_en = 1'b1; a_dis = with_dis;
    @(negedge clk); a_en = 1'b0; a_dis = 1'b0;
    for (int k = 1; k <= A_R + A_S + 3; k++) begin
      if (a_rs) begin n_rs++; if (k_rs < 0) k_rs = k; end
      if (a_cc) begin n_cc++; if (k_cc < 0) k_cc = k; end
      if (a_rc) begin n_rc++; if (k_rc < 0) k_rc = k; end
      if (a_cs) n_cs++;
      if (a_busy) n_busy++;
      if (k == A_R + 5) held_enab = a_enab;
      if (inject && k == A_R + 5) begin a_en = 1'b1; a_dis = 1'b1; end
      if (inject && k == A_R + 6) begin a_en = 1'b0; a_dis = 1'b0; end
      @(negedge clk);
    end
    chk(k_rs == 1, "R3 reset strobe cycle", k_rs, 1);
    chk(k_cc == 1 + A_R, "R4 ungate (clear) cycle", k_cc, 1 + A_R);
    chk(k_rc == 1 + A_R + A_S, "R5 reset release cycle", k_rc, 1 + A_R + A_S);
    chk(n_busy == A_R + A_S, "R5 busy length", n_busy, A_R + A_S);
    chk(held_enab == 0, "R7 status low while held in reset", held_enab, 0);
    chk(n_cs == 0 && n_rs == 1 && n_cc == 1 && n_rc == 1,
        "R9 single pulses, no gating", n_cs, 0);
    chk(a_enab == 1'b1, "R5 enabled after sequence", a_enab, 1);
  endtask

  task automatic watch_quiet_a(input string req, input int cycles);
    int n = 0;
    for (int k = 0; k < cycles; k++) begin
      n += int'(a_cs) + int'(a_cc) + int'(a_rs) + int'(a_rc) + int'(a_busy);
      @(negedge clk);
    end
    chk(n == 0, req, n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset on both instances.
    begin
      int n = 0;
      for (int k = 0; k < 4; k++) begin
        n += int'(a_cs) + int'(a_cc) + int'(a_rs) + int'(a_rc) + int'(a_busy);
        n += int'(b_cs) + int'(b_cc) + int'(b_rs) + int'(b_rc) + int'(b_busy);
        @(negedge clk);
      end
      chk(n == 0, "R1 quiet after reset", n, 0);
    end

    // R7: status sweep, instance A (reset dominates, clock enabling value 0).
    for (int v = 0; v < 4; v++) begin
      load_a(v[1], v[0]);
      chk(a_enab == (!v[0] && !v[1]), "R7 status A", a_enab, int'(!v[0] && !v[1]));
    end
    // R7: status sweep, instance B (no reset line, enabling value 1).
    for (int v = 0; v < 4; v++) begin
      load_b(v[1], v[0]);
      chk(b_enab == v[1], "R7 status B", b_enab, int'(v[1]));
    end

    // Cold state on A: clock stopped and in reset; full sequence with injection.
    load_a(1'b1, 1'b1);
    run_a_enable(1'b0, 1'b1);

    // R2: enable while already enabled does nothing.
    a_en = 1'b1; @(negedge clk); a_en = 1'b0;
    watch_quiet_a("R2 no write when enabled", 5);

    // R8: disable gates only the clock.
    begin
      int k_cs = -1, n_r = 0;
      a_dis = 1'b1; @(negedge clk); a_dis = 1'b0;
      for (int k = 1; k <= 5; k++) begin
        if (a_cs && k_cs < 0) k_cs = k;
        n_r += int'(a_rs) + int'(a_rc);
        @(negedge clk);
      end
      chk(k_cs == 1, "R8 gate strobe cycle", k_cs, 1);
      chk(n_r == 0 && a_rb == 1'b0, "R8 reset untouched", n_r, 0);
      chk(a_enab == 1'b0, "R8 disabled after gating", a_enab, 0);
    end

    // R10: both requests in one idle cycle, enable wins.
    run_a_enable(1'b1, 1'b0);

    // R6 / R4 polarity on B: plain ungate with set strobe.
    load_b(1'b0, 1'b0);
    begin
      int k_cs = -1, n_bad = 0;
      b_en = 1'b1; @(negedge clk); b_en = 1'b0;
      for (int k = 1; k <= 5; k++) begin
        if (b_cs && k_cs < 0) k_cs = k;
        n_bad += int'(b_rs) + int'(b_rc) + int'(b_busy) + int'(b_cc);
        @(negedge clk);
      end
      chk(k_cs == 1, "R6 ungate strobe cycle", k_cs, 1);
      chk(n_bad == 0, "R6 no reset, no busy", n_bad, 0);
      chk(b_enab == 1'b1, "R6 enabled after ungate", b_enab, 1);
    end
    // R8 on B: gate with clear strobe.
    begin
      int k_cc = -1;
      b_dis = 1'b1; @(negedge clk); b_dis = 1'b0;
      for (int k = 1; k <= 3; k++) begin
        if (b_cc && k_cc < 0) k_cc = k;
        @(negedge clk);
      end
      chk(k_cc == 1, "R8 B gate strobe cycle", k_cc, 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule